// File: doc/BRIEF.md
# FFT Operand and Bit-Reversal Address Sequencer

This block produces the memory addresses for a whole radix-2 FFT of size N, one address per enabled clock, so a datapath can run every stage of the transform without a controller stepping in between stages. A single start pulse loads the run. From then on each clock with the enable high yields the next address in the sequence.

Two run modes are offered. The butterfly mode walks all log2N stages. Each butterfly takes two consecutive slots: first the upper operand, then the lower operand, which sits one span above it. The span begins at N/2 and is halved from one stage to the next. The reorder mode walks an index from 0 to N-1 and pairs each index with its bit-reversed value. An exchange is issued only for the smaller member of a pair, so no pair is swapped twice and self-reversed indices cost no memory traffic.

Two synchronised streams are produced. The fetch stream is `addr`. The write-back stream is `wrAddr`, which carries the partner address in reorder mode and the same address in butterfly mode, where results are written in place. Each stage's span and operand mask are held in two shift registers that move once per stage.

Top module: `fft_addr_gen`

## Requirements
- R1: While reset is asserted and after its release, `addrValid`, `stageDone` and `kernelDone` are low and `addr` and `wrAddr` are zero.
- R2: In any clock edge where `agEn` is low, no address is issued. On the next cycle `addrValid` is low and `addr` and `wrAddr` keep their values.
- R3: In butterfly mode (`modeRev`=0), stage s uses span N>>(s+1). Butterfly b of that stage takes two consecutive enabled slots. The first slot carries the upper address (b div span)·2·span + (b mod span). The second slot carries the upper address plus the span.
- R4: A butterfly-mode run covers all log2N stages in increasing order, each with N/2 butterflies, with no intervention. This gives N·log2N valid addresses in total.
- R5: In butterfly mode, `stageDone` is high exactly in the cycle that shows the lower address of the last butterfly of each stage.
- R6: `kernelDone` is high for exactly one cycle, together with the final slot of the run. After it, enabled clocks issue nothing (`addrValid` low) until the next start.
- R7: In reorder mode (`modeRev`=1), an index i with i < rev(i) takes two enabled slots. The first has `addr`=i and `wrAddr`=rev(i). The second has `addr`=rev(i) and `wrAddr`=i. Here rev reverses the log2N index bits.
- R8: In reorder mode, an index i with i >= rev(i) takes one enabled slot. In that slot `addrValid` is low and `addr` and `wrAddr` hold their values.
- R9: In reorder mode, `stageDone` and `kernelDone` are high together in the slot of index N-1, which is the run's only stage.
- R10: A high `start` restarts the sequence from its first slot in the mode given by `modeRev`, whether or not a run is already in progress. The start edge takes priority over `agEn` and issues no address.
- R11: In butterfly mode, every valid slot has `wrAddr` equal to `addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a new run, sampling `modeRev` |
| modeRev | input | 1 | 0 = butterfly stages, 1 = bit-reversal reorder |
| agEn | input | 1 | Address-generate enable; one slot per high clock |
| addr | output | log2N | Fetch-stream address |
| wrAddr | output | log2N | Write-back-stream address |
| addrValid | output | 1 | Slot carries a memory access |
| stageDone | output | 1 | Last slot of a stage |
| kernelDone | output | 1 | Last slot of the run |

## Verification
Some rules are checked by the assertions on every cycle. These are: the hold of both address streams when the enable is low, the in-place write address in butterfly mode, distinct fetch and write addresses in reorder mode, `kernelDone` always coinciding with `stageDone`, and silence on the cycle after a run ends. Other behaviour can only be shown by the bench's scenarios, which compare each enabled slot against an independently computed sequence. That covers the exact operand order across stages, the span halving, the skipping of self-reversed and already-swapped indices, and restarts in the middle of a run under random enable gaps.

// File: rtl/fft_addr_gen_pkg.sv
package fft_addr_gen_pkg;
  // Per-cycle strobes from the sequencing control to the address datapath
  typedef struct packed {
    logic load;       // restart: reset index, span and mask
    logic emit;       // an enabled slot is consumed this edge
    logic valid;      // the slot carries a memory access
    logic sel;        // 0: first member of the pair, 1: second member
    logic stepIdx;    // advance the butterfly / reorder index
    logic stepStage;  // shift span and mask, clear index
    logic stageEnd;   // slot closes a stage
    logic kernelEnd;  // slot closes the run
    logic modeRev;    // latched mode: 1 = reorder
  } strobe_t;
endpackage

// File: rtl/fft_addr_gen_ctrl.sv
module fft_addr_gen_ctrl
  import fft_addr_gen_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    modeIn,
  input  logic    agEn,
  input  logic    lastIdx,
  input  logic    lastStage,
  input  logic    pairHit,
  output strobe_t stb,
  output logic    modeQ
);
  logic running;
  logic phase;
  logic nextPhase;

  always_comb begin
    stb         = '0;
    stb.load    = start;
    stb.modeRev = modeQ;
    nextPhase   = phase;
    if (!start && running && agEn) begin
      stb.emit = 1'b1;
      if (!modeQ) begin
        // butterfly: upper slot, then lower slot
        stb.valid = 1'b1;
        stb.sel   = phase;
        nextPhase = !phase;
        if (phase) begin
          stb.stepIdx = 1'b1;
          if (lastIdx) begin
            stb.stepStage = 1'b1;
            stb.stageEnd  = 1'b1;
            stb.kernelEnd = lastStage;
          end
        end
      end else if (phase) begin
        // reorder: second member of a swap pair
        stb.valid     = 1'b1;
        stb.sel       = 1'b1;
        nextPhase     = 1'b0;
        stb.stepIdx   = 1'b1;
        stb.stageEnd  = lastIdx;
        stb.kernelEnd = lastIdx;
      end else if (pairHit) begin
        stb.valid = 1'b1;
        nextPhase = 1'b1;
      end else begin
        // self-reversed or already swapped: silent slot
        stb.stepIdx   = 1'b1;
        stb.stageEnd  = lastIdx;
        stb.kernelEnd = lastIdx;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      phase   <= 1'b0;
      modeQ   <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      phase   <= 1'b0;
      modeQ   <= modeIn;
    end else if (stb.emit) begin
      phase <= nextPhase;
      if (stb.kernelEnd) running <= 1'b0;
    end
  end
endmodule

// File: rtl/fft_addr_gen_dp.sv
module fft_addr_gen_dp
  import fft_addr_gen_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  output logic          lastIdx,
  output logic          lastStage,
  output logic          pairHit,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] wrAddr,
  output logic          addrValid,
  output logic          stageDone,
  output logic          kernelDone
);
  localparam int HALF = N / 2;
  localparam logic [AW-1:0] TOP_BIT = AW'(1) << (AW - 1);

  logic [AW-1:0] idx;
  logic [AW-1:0] span;    // one-hot distance between operands
  logic [AW-1:0] maskHi;  // ones from the span bit upward
  logic [AW-1:0] revIdx;
  logic [AW-1:0] upperA;
  logic [AW-1:0] lowerA;
  logic [AW-1:0] fetchA;
  logic [AW-1:0] writeA;

  for (genvar k = 0; k < AW; k++) begin : g_rev
    assign revIdx[k] = idx[AW-1-k];
  end

  // insert a zero at the span bit of the butterfly index
  assign upperA = ((idx & maskHi) << 1) | (idx & ~maskHi);
  assign lowerA = upperA | span;

  assign pairHit   = idx < revIdx;
  assign lastIdx   = stb.modeRev ? (idx == {AW{1'b1}}) : (idx == AW'(HALF - 1));
  assign lastStage = span[0];

  always_comb begin
    if (stb.modeRev) begin
      fetchA = stb.sel ? revIdx : idx;
      writeA = stb.sel ? idx : revIdx;
    end else begin
      fetchA = stb.sel ? lowerA : upperA;
      writeA = fetchA;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx    <= '0;
      span   <= TOP_BIT;
      maskHi <= TOP_BIT;
    end else if (stb.load) begin
      idx    <= '0;
      span   <= TOP_BIT;
      maskHi <= TOP_BIT;
    end else if (stb.stepStage) begin
      idx    <= '0;
      span   <= span >> 1;
      maskHi <= {maskHi[AW-1], maskHi[AW-1:1]};
    end else if (stb.stepIdx) begin
      idx <= idx + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr       <= '0;
      wrAddr     <= '0;
      addrValid  <= 1'b0;
      stageDone  <= 1'b0;
      kernelDone <= 1'b0;
    end else begin
      addrValid  <= stb.emit & stb.valid;
      stageDone  <= stb.emit & stb.stageEnd;
      kernelDone <= stb.emit & stb.kernelEnd;
      if (stb.emit && stb.valid) begin
        addr   <= fetchA;
        wrAddr <= writeA;
      end
    end
  end
endmodule

// File: rtl/fft_addr_gen.sv
module fft_addr_gen
  import fft_addr_gen_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          modeRev,
  input  logic          agEn,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] wrAddr,
  output logic          addrValid,
  output logic          stageDone,
  output logic          kernelDone
);
  strobe_t stb;
  logic    lastIdx;
  logic    lastStage;
  logic    pairHit;
  logic    modeQ;

  fft_addr_gen_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .modeIn(modeRev), .agEn(agEn),
    .lastIdx(lastIdx), .lastStage(lastStage), .pairHit(pairHit),
    .stb(stb), .modeQ(modeQ)
  );

  fft_addr_gen_dp #(.N(N), .AW(AW)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .lastIdx(lastIdx), .lastStage(lastStage), .pairHit(pairHit),
    .addr(addr), .wrAddr(wrAddr), .addrValid(addrValid),
    .stageDone(stageDone), .kernelDone(kernelDone)
  );
endmodule

// File: rtl/fft_addr_gen_chk.sv
module fft_addr_gen_chk #(
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rstN,
  input logic          agEn,
  input logic          modeQ,
  input logic [AW-1:0] addr,
  input logic [AW-1:0] wrAddr,
  input logic          addrValid,
  input logic          stageDone,
  input logic          kernelDone
);
  // R2: a disabled edge issues nothing and holds both streams
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !agEn |=> (!addrValid && $stable(addr) && $stable(wrAddr)));

  // R11: butterfly results are written in place
  a_r11_in_place: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && !modeQ) |-> (wrAddr == addr));

  // R7: a reorder slot always pairs two distinct locations
  a_r7_distinct_pair: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && modeQ) |-> (wrAddr != addr));

  // R6: the run end also closes a stage
  a_r6_end_closes_stage: assert property (@(posedge clk) disable iff (!rstN)
    kernelDone |-> stageDone);

  // R6: nothing is issued right after the run end
  a_r6_silent_after_end: assert property (@(posedge clk) disable iff (!rstN)
    kernelDone |=> (!addrValid && !kernelDone));
endmodule

bind fft_addr_gen fft_addr_gen_chk #(.AW(AW)) chk_i (
  .clk(clk), .rstN(rstN), .agEn(agEn), .modeQ(modeQ),
  .addr(addr), .wrAddr(wrAddr), .addrValid(addrValid),
  .stageDone(stageDone), .kernelDone(kernelDone)
);

// File: tb/fft_addr_gen_tb_top.sv
module fft_addr_gen_tb_top;
  localparam int N  = 16;
  localparam int AW = $clog2(N);
  localparam int MAXE = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic modeRev = 1'b0;
  logic agEn = 1'b0;
  logic [AW-1:0] addr, wrAddr;
  logic addrValid, stageDone, kernelDone;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  logic          expV [MAXE];
  logic [AW-1:0] expA [MAXE];
  logic [AW-1:0] expW [MAXE];
  logic          expS [MAXE];
  logic          expK [MAXE];
  int            expLen;

  always #2 clk = ~clk;  // 250 MHz

  fft_addr_gen #(.N(N)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .modeRev(modeRev), .agEn(agEn),
    .addr(addr), .wrAddr(wrAddr), .addrValid(addrValid),
    .stageDone(stageDone), .kernelDone(kernelDone)
  );

  function automatic int bitRev(int v);
    int r = 0;
    for (int k = 0; k < AW; k++) if (v[k]) r |= 1 << (AW - 1 - k);
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input bit v, input int a, input int w, input bit s, input bit k);
    expV[expLen] = v; expA[expLen] = AW'(a); expW[expLen] = AW'(w);
    expS[expLen] = s; expK[expLen] = k; expLen++;
  endtask

  // R3 R4 R5 R6: butterfly sequence model
  task automatic buildButterfly();
    expLen = 0;
    for (int s = 0; s < AW; s++) begin
      int h = N >> (s + 1);
      for (int b = 0; b < N / 2; b++) begin
        int up = (b / h) * 2 * h + (b % h);
        bit last = (b == N / 2 - 1);
        push(1'b1, up, up, 1'b0, 1'b0);
        push(1'b1, up + h, up + h, last, last && (s == AW - 1));
      end
    end
  endtask

  // R7 R8 R9: reorder sequence model
  task automatic buildReorder();
    expLen = 0;
    for (int i = 0; i < N; i++) begin
      int r = bitRev(i);
      bit last = (i == N - 1);
      if (i < r) begin
        push(1'b1, i, r, 1'b0, 1'b0);
        push(1'b1, r, i, last, last);
      end else begin
        push(1'b0, 0, 0, last, last);
      end
    end
  endtask

  // one run; limit < expLen ends it early (restart follows, R10)
  task automatic runKernel(input bit mode, input int pct, input int limit);
    int pos = 0;
    logic [AW-1:0] heldA, heldW;
    string tag;
    if (mode) buildReorder(); else buildButterfly();
    tag = mode ? "R7/R8/R9" : "R3/R4/R5/R6/R11";
    heldA = addr; heldW = wrAddr;
    start = 1'b1; modeRev = mode; agEn = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!addrValid && addr == heldA && !kernelDone, "R10 start edge silent",
          {addrValid, addr}, {1'b0, heldA});
    while (pos < expLen && pos < limit) begin
      agEn = (($urandom % 100) < pct);
      @(negedge clk);
      if (agEn) begin
        logic [AW-1:0] ea = expV[pos] ? expA[pos] : heldA;
        logic [AW-1:0] ew = expV[pos] ? expW[pos] : heldW;
        check(addrValid == expV[pos] && addr == ea && wrAddr == ew &&
              stageDone == expS[pos] && kernelDone == expK[pos], tag,
              {addrValid, stageDone, kernelDone, addr, wrAddr},
              {expV[pos], expS[pos], expK[pos], ea, ew});
        heldA = ea; heldW = ew;
        pos++;
      end else begin
        check(!addrValid && !stageDone && !kernelDone && addr == heldA && wrAddr == heldW,
              "R2 disabled edge holds", {addrValid, addr, wrAddr}, {1'b0, heldA, heldW});
      end
    end
    if (pos >= expLen) begin
      agEn = 1'b1;
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        check(!addrValid && !kernelDone && addr == heldA, "R6 idle after end",
              {addrValid, kernelDone, addr}, {2'b00, heldA});
      end
    end
    agEn = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check(!addrValid && !stageDone && !kernelDone && addr == '0 && wrAddr == '0,
          "R1 in reset", {addrValid, stageDone, kernelDone, addr}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!addrValid && addr == '0, "R1 after release", {addrValid, addr}, 0);
    runKernel(1'b0, 100, MAXE);  // dense butterfly run
    runKernel(1'b1, 100, MAXE);  // dense reorder run
    runKernel(1'b0, 60, MAXE);   // gapped butterfly run
    runKernel(1'b1, 50, MAXE);   // gapped reorder run
    runKernel(1'b0, 80, 21);     // abandoned mid-stage, R10
    runKernel(1'b1, 80, MAXE);   // restart in the other mode
    runKernel(1'b1, 70, 5);      // abandoned reorder
    runKernel(1'b0, 75, MAXE);   // restart into butterfly
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule